// File: doc/BRIEF.md
# Symmetric Up/Down PWM Timer

An 8-bit timer whose count climbs from zero to a ceiling and then falls back to zero, producing two centre-aligned pulse-width waveforms whose edges sit symmetrically about the bottom of the count. A clock-enable generated by an internal divider sets the count rate. Each channel compares the count against its own threshold. The level drops when a match occurs on the way up and rises when a match occurs on the way down. Extreme thresholds pin the level low or high, and the ceiling forces the up-count level so the waveform stays symmetric even when a match was skipped.

Software loads thresholds and a control byte through a simple write port. Threshold writes sit in a shadow register until the count reaches its ceiling, or pass through at once while the timer is halted. Three sticky event flags (bottom reached, channel A match, channel B match) can be cleared by writing ones or by an interrupt acknowledge. Each flag raises an interrupt request when its enable bit is set.

Top module: `pcpwm_top`

## Requirements
- R1: After synchronous reset the count is 0 and rising, both waveform levels are low, both pins are 0, and all flags and interrupt requests are 0.
- R2: On each divider tick the count steps by one, rising from 0 to the ceiling and then falling back to 0. With the ceiling at 255 one full period is 510 ticks.
- R3: Control bit 0 selects the ceiling. 0 selects 255, and 1 selects the active threshold of channel A, which gives a period of twice that value in ticks.
- R4: `clk_sel` values 1 to 7 give one tick every 1, 8, 32, 64, 128, 256 or 1024 clocks. Value 0 halts the timer, so there are no ticks and the pins and flags hold.
- R5: In output mode 2 (and mode 1), a match while rising drives the level low and a match while falling drives it high. For a threshold c with 0 < c < ceiling, the pin is high for 2c ticks per period.
- R6: A threshold of 0 keeps the level low and a threshold at or above the ceiling keeps it high. Output mode 3 drives the pin with the inverse of the level.
- R7: On the tick at the ceiling the level takes the rising-match value (low), based on the incoming threshold, unless R6 applies. This holds even when no match occurred.
- R8: Output mode 0 holds the pin at 0.
- R9: Writes to address 0 (threshold A) or 1 (threshold B) go to a shadow register. The active threshold is loaded from the shadow on the tick at the ceiling, or on every clock while `clk_sel` is 0.
- R10: A flag bit is set on a tick where the count equals a channel's active threshold (bit 1 for A, bit 2 for B). Bit 0 is set on the tick where the count is 0 while falling.
- R11: A one in `flag_clr` or `irq_ack` clears the matching flag bit. A set in the same cycle takes priority over the clear.
- R12: `irq[i]` is high only while flag bit i is set and its enable is set. Control byte (address 2) layout: bit 0 ceiling select, bits 2:1 output mode A, bits 4:3 output mode B, bits 7:5 enables for flags 0, 1, 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 3 | Divider select, 0 halts |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 threshold A, 1 threshold B, 2 control |
| wr_data | input | 8 | Write data |
| flag_clr | input | 3 | Write-one-to-clear for flags |
| irq_ack | input | 3 | Interrupt serviced, clears flag |
| pwm_a | output | 1 | Channel A waveform pin |
| pwm_b | output | 1 | Channel B waveform pin |
| flags | output | 3 | {B match, A match, bottom} |
| irq | output | 3 | Enabled interrupt requests |

## Verification
A flag set by a count event and a clear from software can land on the same clock. The bench provokes this by holding every clear bit high for a whole period while matches and bottom turns keep occurring. It then judges that each flag is still seen for exactly one cycle per event, two per period for each channel and one for the bottom. A threshold load at the ceiling and the forced ceiling level also coincide on one tick. This is driven by rewriting thresholds away from 255 while the timer runs, and every cycle of the pins is compared against the bench's own model.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_PLAIN  = 2'd1,
        OUT_NONINV = 2'd2,
        OUT_INV    = 2'd3
    } out_mode_e;

    // control byte, MSB first
    typedef struct packed {
        logic      en_b;
        logic      en_a;
        logic      en_ovf;
        out_mode_e mode_b;
        out_mode_e mode_a;
        logic      top_sel;
    } ctrl_t;

    typedef struct packed {
        logic match_b;
        logic match_a;
        logic bottom;
    } flag_t;

    localparam logic [1:0] ADDR_CMP_A = 2'd0;
    localparam logic [1:0] ADDR_CMP_B = 2'd1;
    localparam logic [1:0] ADDR_CTRL  = 2'd2;

    function automatic int unsigned div_of(input logic [2:0] sel);
        case (sel)
            3'd1:    return 1;
            3'd2:    return 8;
            3'd3:    return 32;
            3'd4:    return 64;
            3'd5:    return 128;
            3'd6:    return 256;
            3'd7:    return 1024;
            default: return 1;
        endcase
    endfunction

    function automatic logic pin_level(input out_mode_e m, input logic lvl);
        case (m)
            OUT_OFF: return 1'b0;
            OUT_INV: return ~lvl;
            default: return lvl;
        endcase
    endfunction

endpackage

// File: rtl/pcpwm_prescaler.sv
module pcpwm_prescaler #(
    parameter int PS_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] sel,
    output logic       tick
);
    import pcpwm_pkg::*;

    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] limit;

    always_comb begin
        limit = PS_W'(div_of(sel) - 1);
        tick  = (sel != 3'd0) && (pcnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst || sel == 3'd0 || tick) pcnt <= '0;
        else                            pcnt <= pcnt + PS_W'(1);
    end

    // R4: dividers of 8 and more never tick on two clocks in a row
    a_r4_tick_gap: assert property (@(posedge clk) disable iff (rst)
        (tick && sel > 3'd1) |=> (!tick || sel != $past(sel)));

endmodule

// File: rtl/pcpwm_updown.sv
module pcpwm_updown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic         dir_up,
    output logic         at_top,
    output logic         at_bottom
);
    always_comb begin
        at_top    = dir_up && (cnt >= top);
        at_bottom = !dir_up && (cnt == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            dir_up <= 1'b1;
        end else if (tick) begin
            if (at_top) begin
                dir_up <= 1'b0;
                cnt    <= (cnt == '0) ? '0 : cnt - W'(1);
            end else if (at_bottom) begin
                dir_up <= 1'b1;
                cnt    <= (top == '0) ? '0 : W'(1);
            end else if (dir_up) begin
                cnt <= cnt + W'(1);
            end else begin
                cnt <= cnt - W'(1);
            end
        end
    end

    // R2: a tick moves the count by exactly one
    a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
        (tick && top != '0) |=> (cnt == W'($past(cnt) + W'(1)) || cnt == W'($past(cnt) - W'(1))));
    // R4: without a tick the count holds
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt) && $stable(dir_up));

endmodule

// File: rtl/pcpwm_channel.sv
module pcpwm_channel #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         load,
    input  logic         wr_buf,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] cnt,
    input  logic         dir_up,
    input  logic         at_top,
    input  logic [W-1:0] top,
    output logic         lvl,
    output logic         hit,
    output logic [W-1:0] act_cmp
);
    logic [W-1:0] shadow;
    logic [W-1:0] cmp_eff;
    logic         lvl_next;

    always_comb begin
        cmp_eff  = load ? shadow : act_cmp;
        hit      = tick && (cnt == act_cmp);
        lvl_next = lvl;
        if (cmp_eff == '0)          lvl_next = 1'b0;
        else if (cmp_eff >= top)    lvl_next = 1'b1;
        else if (at_top)            lvl_next = 1'b0;
        else if (cnt == cmp_eff)    lvl_next = !dir_up;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            act_cmp <= '0;
            lvl     <= 1'b0;
        end else begin
            if (wr_buf) shadow  <= wr_val;
            if (load)   act_cmp <= shadow;
            if (tick)   lvl     <= lvl_next;
        end
    end

    // R9: the active threshold moves only on a load
    a_r9_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(act_cmp));
    // R6: zero threshold keeps the level low
    a_r6_zero_low: assert property (@(posedge clk) disable iff (rst)
        (tick && cmp_eff == '0) |=> !lvl);
    // R6: threshold at or above the ceiling keeps the level high
    a_r6_max_high: assert property (@(posedge clk) disable iff (rst)
        (tick && cmp_eff != '0 && cmp_eff >= top) |=> lvl);
    // R7: ceiling forces the rising-match level
    a_r7_top_low: assert property (@(posedge clk) disable iff (rst)
        (tick && at_top && cmp_eff != '0 && cmp_eff < top) |=> !lvl);

endmodule

// File: rtl/pcpwm_flags.sv
module pcpwm_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] flags,
    output logic [N-1:0] irq
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | set;
    end

    always_comb irq = flags & en;

    // R10: every set shows up on the next cycle
    a_r10_set_seen: assert property (@(posedge clk) disable iff (rst)
        (set != '0) |=> ((flags & $past(set)) == $past(set)));
    // R11: a clear without a competing set empties the bit
    a_r11_clear_wins_alone: assert property (@(posedge clk) disable iff (rst)
        ((clr & ~set) != '0) |=> ((flags & $past(clr & ~set)) == '0));

endmodule

// File: rtl/pcpwm_top.sv
module pcpwm_top #(
    parameter int W    = 8,
    parameter int PS_W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   clk_sel,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic [2:0]   flag_clr,
    input  logic [2:0]   irq_ack,
    output logic         pwm_a,
    output logic         pwm_b,
    output logic [2:0]   flags,
    output logic [2:0]   irq
);
    import pcpwm_pkg::*;

    localparam int NCH = 2;

    ctrl_t        ctrl_q;
    logic         tick;
    logic [W-1:0] cnt;
    logic [W-1:0] top;
    logic         dir_up, at_top, at_bottom, load;
    logic [NCH-1:0] lvl, hit;
    logic [W-1:0] act_cmp [NCH];
    flag_t        set_v;
    logic [2:0]   en_v;

    always_ff @(posedge clk) begin
        if (rst)                                  ctrl_q <= '0;
        else if (wr_en && wr_addr == ADDR_CTRL)   ctrl_q <= ctrl_t'(wr_data);
    end

    pcpwm_prescaler #(.PS_W(PS_W)) u_ps (
        .clk(clk), .rst(rst), .sel(clk_sel), .tick(tick)
    );

    always_comb begin
        top  = ctrl_q.top_sel ? act_cmp[0] : '1;
        load = (clk_sel == 3'd0) || (tick && at_top);
    end

    pcpwm_updown #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .top(top),
        .cnt(cnt), .dir_up(dir_up), .at_top(at_top), .at_bottom(at_bottom)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pcpwm_channel #(.W(W)) u_ch (
            .clk(clk), .rst(rst), .tick(tick), .load(load),
            .wr_buf(wr_en && wr_addr == 2'(g)), .wr_val(wr_data),
            .cnt(cnt), .dir_up(dir_up), .at_top(at_top), .top(top),
            .lvl(lvl[g]), .hit(hit[g]), .act_cmp(act_cmp[g])
        );
    end

    always_comb begin
        pwm_a         = pin_level(ctrl_q.mode_a, lvl[0]);
        pwm_b         = pin_level(ctrl_q.mode_b, lvl[1]);
        set_v.bottom  = tick && at_bottom;
        set_v.match_a = hit[0];
        set_v.match_b = hit[1];
        en_v          = {ctrl_q.en_b, ctrl_q.en_a, ctrl_q.en_ovf};
    end

    pcpwm_flags #(.N(3)) u_flags (
        .clk(clk), .rst(rst), .set(set_v), .clr(flag_clr | irq_ack),
        .en(en_v), .flags(flags), .irq(irq)
    );

    // R8: a channel in mode 0 never drives its pin
    a_r8_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.mode_a == OUT_OFF) |-> !pwm_a);
    // R12: a disabled request stays low
    a_r12_masked: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.en_a |-> !irq[1]);

endmodule

// File: tb/tb_pcpwm_top.sv
module tb_pcpwm_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] clk_sel;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] flag_clr;
    logic [2:0] irq_ack;
    logic       pwm_a, pwm_b;
    logic [2:0] flags, irq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcpwm_top dut (
        .clk(clk), .rst(rst), .clk_sel(clk_sel), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .flag_clr(flag_clr), .irq_ack(irq_ack),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .flags(flags), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    int m_ps, m_cnt, m_up;
    int m_lvl [2];
    int m_shadow [2];
    int m_act [2];
    int m_ctrl;
    bit [2:0] m_flags;

    function automatic int divider(input int s);
        int d;
        d = 1;
        for (int k = 1; k < s; k++) d = (k == 1) ? 8 : d * 2;
        if (s >= 3) d = 8 << (2 * 1 + (s - 3) - 1 + 1 - 1);
        case (s)
            3: d = 32; 4: d = 64; 5: d = 128; 6: d = 256; 7: d = 1024;
            default: ;
        endcase
        return d;
    endfunction

    function automatic bit pin_of(input int mode, input int lvl);
        if (mode == 0) return 1'b0;
        if (mode == 3) return (lvl == 0);
        return (lvl != 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ps = 0; m_cnt = 0; m_up = 1; m_ctrl = 0; m_flags = 3'b000;
            for (int i = 0; i < 2; i++) begin
                m_lvl[i] = 0; m_shadow[i] = 0; m_act[i] = 0;
            end
        end else begin
            int s, tk, tp, hi, lo, ld, eff;
            bit [2:0] setv;
            s  = int'(clk_sel);
            tk = (s != 0 && m_ps >= divider(s) - 1) ? 1 : 0;
            m_ps = (s == 0 || tk != 0) ? 0 : m_ps + 1;
            tp = (m_ctrl % 2 == 1) ? m_act[0] : 255;
            hi = (m_up != 0 && m_cnt >= tp) ? 1 : 0;
            lo = (m_up == 0 && m_cnt == 0) ? 1 : 0;
            ld = (s == 0 || (tk != 0 && hi != 0)) ? 1 : 0;
            setv[0] = (tk != 0 && lo != 0);
            for (int i = 0; i < 2; i++) begin
                eff = (ld != 0) ? m_shadow[i] : m_act[i];
                setv[i+1] = (tk != 0 && m_cnt == m_act[i]);
                if (tk != 0) begin
                    if (eff == 0)            m_lvl[i] = 0;
                    else if (eff >= tp)      m_lvl[i] = 1;
                    else if (hi != 0)        m_lvl[i] = 0;
                    else if (m_cnt == eff)   m_lvl[i] = (m_up != 0) ? 0 : 1;
                end
                if (ld != 0) m_act[i] = m_shadow[i];
            end
            m_flags = (m_flags & ~(flag_clr | irq_ack)) | setv;
            if (tk != 0) begin
                if (hi != 0) begin
                    m_up = 0; if (m_cnt > 0) m_cnt = m_cnt - 1;
                end else if (lo != 0) begin
                    m_up = 1; m_cnt = (tp == 0) ? 0 : 1;
                end else begin
                    m_cnt = (m_up != 0) ? m_cnt + 1 : m_cnt - 1;
                end
            end
            if (wr_en) begin
                if (wr_addr == 2'd0) m_shadow[0] = int'(wr_data);
                if (wr_addr == 2'd1) m_shadow[1] = int'(wr_data);
                if (wr_addr == 2'd2) m_ctrl      = int'(wr_data);
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            bit ea, eb;
            bit [2:0] ei;
            ea = pin_of((m_ctrl >> 1) % 4, m_lvl[0]);
            eb = pin_of((m_ctrl >> 3) % 4, m_lvl[1]);
            ei = m_flags & 3'((m_ctrl >> 5) % 8);
            vectors++;
            if (pwm_a !== ea) begin
                fails++; $display("FAIL pwm_a (R5 R6 R7 R8 R9) actual=%0b expected=%0b t=%0t", pwm_a, ea, $time);
            end
            if (pwm_b !== eb) begin
                fails++; $display("FAIL pwm_b (R5 R6 R7 R8 R9) actual=%0b expected=%0b t=%0t", pwm_b, eb, $time);
            end
            if (flags !== m_flags) begin
                fails++; $display("FAIL flags (R10 R11) actual=%b expected=%b t=%0t", flags, m_flags, $time);
            end
            if (irq !== ei) begin
                fails++; $display("FAIL irq (R12) actual=%b expected=%b t=%0t", irq, ei, $time);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic count_high(input int n, output int ha, output int hb);
        ha = 0; hb = 0;
        repeat (n) begin
            @(negedge clk);
            ha += int'(pwm_a); hb += int'(pwm_b);
        end
    endtask

    task automatic ovf_gap(output int gap);
        int guard;
        flag_clr[0] = 1'b1;
        @(negedge clk);
        guard = 0;
        do begin @(negedge clk); guard++; end while (!flags[0] && guard < 40000);
        gap = 0;
        do begin @(negedge clk); gap++; end while (!flags[0] && gap < 40000);
        flag_clr[0] = 1'b0;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int ha, hb, gap, ca, cb, co;
        bit pa, pb;
        rst = 1'b1; clk_sel = 3'd0; wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'd0;
        flag_clr = 3'b000; irq_ack = 3'b000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pwm_a", int'(pwm_a), 0);
        chk("R1 pwm_b", int'(pwm_b), 0);
        chk("R1 flags", int'(flags), 0);
        chk("R1 irq", int'(irq), 0);

        // halted: thresholds pass straight through (R9)
        wr(0, 100); wr(1, 0); wr(2, 8'hFC);
        @(negedge clk); clk_sel = 3'd1;
        repeat (520) @(negedge clk);
        count_high(510, ha, hb);
        chk("R5 duty A c=100", ha, 200);
        chk("R6 inverted B c=0", hb, 510);
        ovf_gap(gap);
        chk("R2 period 510", gap, 510);

        // running rewrite, loaded at the ceiling (R9), extremes (R6)
        wr(0, 255); wr(1, 254);
        repeat (1100) @(negedge clk);
        count_high(510, ha, hb);
        chk("R6 A c=255 high", ha, 510);
        chk("R6 B inverted c=254", hb, 2);

        // step away from MAX: ceiling forcing keeps symmetry (R7)
        wr(1, 10); wr(2, 8'hF4);
        repeat (1100) @(negedge clk);
        count_high(510, ha, hb);
        chk("R7 B c=10 from 254", hb, 20);

        // mode 0 (R8)
        wr(2, 8'hF0);
        repeat (20) @(negedge clk);
        count_high(510, ha, hb);
        chk("R8 A off", ha, 0);

        // ceiling from threshold A (R3)
        wr(0, 60); wr(1, 20); wr(2, 8'hF5);
        repeat (1100) @(negedge clk);
        ovf_gap(gap);
        chk("R3 period 120", gap, 120);
        count_high(120, ha, hb);
        chk("R3 B c=20 in 120", hb, 40);
        chk("R3 A at ceiling high", ha, 120);

        // divider by 8 (R4)
        @(negedge clk); clk_sel = 3'd2;
        ovf_gap(gap);
        chk("R4 period div8", gap, 960);
        repeat (1100) @(negedge clk);

        // halt (R4): nothing moves
        clk_sel = 3'd0;
        @(negedge clk);
        pa = pwm_a; pb = pwm_b;
        chk("R10 all flags set", int'(flags), 7);
        repeat (100) @(negedge clk);
        chk("R4 halt A stable", int'(pwm_a), int'(pa));
        chk("R4 halt B stable", int'(pwm_b), int'(pb));
        chk("R4 halt flags stable", int'(flags), 7);

        // acknowledge and masks (R11, R12)
        irq_ack = 3'b010; @(negedge clk); irq_ack = 3'b000;
        chk("R11 ack clears A", int'(flags[1]), 0);
        chk("R12 irq follows", int'(irq), 5);
        wr(2, 8'h15);
        @(negedge clk);
        chk("R12 masked irq", int'(irq), 0);
        chk("R12 flags kept", int'(flags), 5);
        flag_clr = 3'b101; @(negedge clk); flag_clr = 3'b000;
        chk("R11 w1c", int'(flags), 0);

        // set and clear collide (R10, R11)
        wr(2, 8'hF4);
        @(negedge clk); clk_sel = 3'd1;
        repeat (600) @(negedge clk);
        flag_clr = 3'b111;
        @(negedge clk);
        ca = 0; cb = 0; co = 0;
        repeat (510) begin
            @(negedge clk);
            ca += int'(flags[1]); cb += int'(flags[2]); co += int'(flags[0]);
        end
        flag_clr = 3'b000;
        chk("R11 collide A seen", ca, 2);
        chk("R11 collide B seen", cb, 2);
        chk("R10 bottom once", co, 1);

        // divider by 32 (R4)
        clk_sel = 3'd3;
        ovf_gap(gap);
        chk("R4 period div32", gap, 16320);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule